// File: doc/BRIEF.md
# Memory Traffic Generator and Checker

This block drives traffic into a word-wide memory port and checks what comes back. A run starts with a start pulse. At that moment the block latches the address count, the data source and the transaction mode. Each iteration then walks the addresses 0 to N-1. Depending on the mode, an iteration writes every address, reads every address, or writes every address and then reads them all back. Iterations repeat until a stop pulse arrives. The stop takes effect when the current iteration has finished. On the read side, every returned word is compared against a value that the block regenerates from the same source used for writing.

There are three data sources: a 31-bit pseudo-random sequence, a small computed pattern table, and an arithmetic function of the address. A one-word error can be injected on request. The block keeps separate counters for injected errors and detected mismatches, plus write-word and read-word counters for throughput. The write and read counters restart with every run.

The request channel is valid/ready. While `mem_req_valid` is high and `mem_req_ready` is low, the request must be held unchanged. The response channel carries no back-pressure. While a run is reading, the block accepts one `mem_rsp_valid` word per cycle. The responses must come back in request order, at least one cycle after the read handshake. Responses that arrive while the block is not reading are ignored.

Top module: `memtest_engine`

## Requirements
- R1: The address count is latched at start and clamped into 8..8192: a value below 8 becomes 8 and a value above 8192 becomes 8192. Each iteration issues addresses 0 to N-1 in ascending order.
- R2: The mode code selects the iteration type. Code 1 issues reads only. Code 2 issues writes only. Codes 0 and 3 issue all N writes and then all N reads. No request is issued while idle.
- R3: Source code 0 is the pseudo-random sequence. Its 31-bit state is x^31+x^28+1 in Fibonacci form, and each step computes next = {s[29:0], s[30]^s[27]}. The state is loaded with 1 at the start of every write pass and every read pass. A word carries the current state, zero-extended, and the state steps once per word.
- R4: Source code 1 is the table. The word for address a is the byte {a[3:0], ~a[3:0]} repeated across the word.
- R5: Source codes 2 and 3 are the arithmetic source. The word is the address plus 32'h1000_0000.
- R6: A response is accepted while the block is reading. Every accepted response that differs from its expected word raises err_detected by one.
- R7: An injection request accepted during a run raises err_inserted by one in the next cycle. It inverts bit 0 of exactly one later word. In the write modes this is the next write word that is first offered after acceptance. In read-only mode it is the expected value of the next response.
- R8: An injection request made while no run is active is ignored: err_inserted is unchanged and no word is corrupted.
- R9: counters_clear zeroes err_detected and err_inserted. An event in the same cycle as the clear is still counted, so that counter reads 1.
- R10: wr_words counts write handshakes and rd_words counts accepted responses. Both are zeroed by an accepted start, and both saturate at their maximum value instead of wrapping.
- R11: A stalled request (valid high, ready low) keeps valid, address, write-enable and write data unchanged in the next cycle.
- R12: A stop pulse ends the run only after the current iteration has completed, including all of its responses. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_count | input | NW | Addresses per iteration, latched at start |
| cfg_src | input | 2 | Data source: 0 pseudo-random, 1 table, 2/3 arithmetic |
| cfg_mode | input | 2 | 0/3 write then read, 1 read only, 2 write only |
| run_start | input | 1 | One-cycle pulse that starts a run from idle |
| run_stop | input | 1 | One-cycle pulse that ends the run after the current iteration |
| inject_req | input | 1 | One-cycle pulse requesting one corrupted word |
| counters_clear | input | 1 | Zeroes both error counters |
| running | output | 1 | High while a run is active |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| err_detected | output | ECW | Mismatching read words |
| err_inserted | output | ECW | Accepted injection requests |
| wr_words | output | TPW | Write words since start (saturating) |
| rd_words | output | TPW | Read words since start (saturating) |

## Verification
Two pairs of events can fall in the same cycle. The first is a counter clear together with an accepted injection. The bench raises counters_clear, inject_req and run_stop in the cycle right after a start, and then expects err_inserted to read 1 and err_detected to read 0. The second is an injection request together with a write word that is already being offered. The block must let that word pass clean and corrupt the following one. The scoreboard therefore expects bit 0 of word 1, not word 0, to be inverted. The request channel is stalled at random throughout, so the rule that a stalled word may not change is exercised in the middle of injections as well.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [1:0] SRC_PRBS  = 2'd0;
  localparam logic [1:0] SRC_TABLE = 2'd1;

  localparam logic [1:0] MODE_RD_ONLY = 2'd1;
  localparam logic [1:0] MODE_WR_ONLY = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR    = 2'd1,
    ST_RD    = 2'd2,
    ST_DRAIN = 2'd3
  } mt_state_e;
endpackage

// File: rtl/mt_pattern.sv
module mt_pattern #(
  parameter int          DW        = 32,
  parameter int          AW        = 13,
  parameter logic [30:0] SEED      = 31'h1,
  parameter logic [DW-1:0] ARITH_OFS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reseed,
  input  logic          step,
  input  logic [1:0]    src,
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] data
);
  import mt_pkg::*;

  localparam int NBYTES = DW / 8;

  logic [30:0]   lfsr_q;
  logic [DW-1:0] tbl_w;
  logic [DW-1:0] prbs_w;
  logic [DW-1:0] arith_w;

  // Fibonacci form of x^31 + x^28 + 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= SEED;
    else if (reseed) lfsr_q <= SEED;
    else if (step)   lfsr_q <= {lfsr_q[29:0], lfsr_q[30] ^ lfsr_q[27]};
  end

  always_comb begin
    tbl_w = '0;
    for (int b = 0; b < NBYTES; b++) begin
      tbl_w[b*8 +: 8] = {idx[3:0], ~idx[3:0]};
    end
  end

  assign prbs_w  = DW'(lfsr_q);
  assign arith_w = DW'(idx) + ARITH_OFS;

  always_comb begin
    unique case (src)
      SRC_PRBS:  data = prbs_w;
      SRC_TABLE: data = tbl_w;
      default:   data = arith_w;
    endcase
  end
endmodule

// File: rtl/mt_sat_ctr.sv
module mt_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= inc ? W'(1) : '0;
    else if (inc && q != '1)    q <= q + 1'b1;
  end
endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import mt_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          MIN_ADDRS = 8,
  parameter int          MAX_ADDRS = 8192,
  parameter int          ECW       = 32,
  parameter int          TPW       = 32,
  parameter int          PIW       = 4,
  parameter logic [30:0] SEED      = 31'h1,
  parameter logic [DW-1:0] ARITH_OFS = DW'(32'h1000_0000),
  localparam int         AW        = $clog2(MAX_ADDRS),
  localparam int         NW        = $clog2(MAX_ADDRS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NW-1:0]  cfg_addr_count,
  input  logic [1:0]     cfg_src,
  input  logic [1:0]     cfg_mode,
  input  logic           run_start,
  input  logic           run_stop,
  input  logic           inject_req,
  input  logic           counters_clear,
  output logic           running,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_we,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic [ECW-1:0] err_detected,
  output logic [ECW-1:0] err_inserted,
  output logic [TPW-1:0] wr_words,
  output logic [TPW-1:0] rd_words
);
  mt_state_e      st_q, st_d;
  logic [AW-1:0]  addr_q;
  logic [NW-1:0]  n_q, n_clamped, rsp_cnt_q;
  logic [1:0]     mode_q, src_q;
  logic           stop_q;
  logic [PIW-1:0] inj_pend_q;
  logic           hold_q, corrupt_q;

  logic start_go, stop_now, last_addr, drain_done;
  logic wr_hs, rd_hs, rsp_take;
  logic mode_ro, mode_wo;
  logic reseed_w, reseed_c;
  logic inj_acc, pend_nz, word_flip, chk_flip, consume, mismatch;
  logic [DW-1:0] exp_word;

  logic          pat_reseed [2];
  logic          pat_step   [2];
  logic [AW-1:0] pat_idx    [2];
  logic [DW-1:0] pat_data   [2];

  // Clamp the requested count into the legal window
  always_comb begin
    if (cfg_addr_count < NW'(MIN_ADDRS))      n_clamped = NW'(MIN_ADDRS);
    else if (cfg_addr_count > NW'(MAX_ADDRS)) n_clamped = NW'(MAX_ADDRS);
    else                                      n_clamped = cfg_addr_count;
  end

  assign running    = (st_q != ST_IDLE);
  assign start_go   = run_start && (st_q == ST_IDLE);
  assign stop_now   = stop_q || run_stop;
  assign mode_ro    = (mode_q == MODE_RD_ONLY);
  assign mode_wo    = (mode_q == MODE_WR_ONLY);
  assign last_addr  = (NW'(addr_q) == n_q - NW'(1));
  assign drain_done = (rsp_cnt_q == n_q);

  assign mem_req_valid = (st_q == ST_WR) || (st_q == ST_RD);
  assign mem_req_we    = (st_q == ST_WR);
  assign mem_req_addr  = addr_q;

  assign wr_hs    = mem_req_valid && mem_req_ready && (st_q == ST_WR);
  assign rd_hs    = mem_req_valid && mem_req_ready && (st_q == ST_RD);
  assign rsp_take = mem_rsp_valid && ((st_q == ST_RD) || (st_q == ST_DRAIN));

  // Iteration sequencing
  always_comb begin
    st_d     = st_q;
    reseed_w = 1'b0;
    reseed_c = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_go) begin
          st_d     = (cfg_mode == MODE_RD_ONLY) ? ST_RD : ST_WR;
          reseed_w = 1'b1;
          reseed_c = 1'b1;
        end
      end
      ST_WR: begin
        if (wr_hs && last_addr) begin
          if (mode_wo) begin
            if (stop_now) st_d = ST_IDLE;
            else          reseed_w = 1'b1;
          end else begin
            st_d     = ST_RD;
            reseed_c = 1'b1;
          end
        end
      end
      ST_RD: begin
        if (rd_hs && last_addr) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (drain_done) begin
          if (stop_now) begin
            st_d = ST_IDLE;
          end else if (mode_ro) begin
            st_d     = ST_RD;
            reseed_c = 1'b1;
          end else begin
            st_d     = ST_WR;
            reseed_w = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      n_q       <= NW'(MIN_ADDRS);
      rsp_cnt_q <= '0;
      mode_q    <= '0;
      src_q     <= '0;
      stop_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_go) begin
        addr_q <= '0;
        n_q    <= n_clamped;
        mode_q <= cfg_mode;
        src_q  <= cfg_src;
        stop_q <= 1'b0;
      end else begin
        if (run_stop && running) stop_q <= 1'b1;
        if (wr_hs || rd_hs)      addr_q <= last_addr ? '0 : addr_q + 1'b1;
      end
      if (reseed_c)      rsp_cnt_q <= '0;
      else if (rsp_take) rsp_cnt_q <= rsp_cnt_q + 1'b1;
    end
  end

  // Error injection: the corruption decision for a write word is frozen
  // once the word has been offered and stalled.
  assign pend_nz   = (inj_pend_q != '0);
  assign inj_acc   = inject_req && running && (inj_pend_q != '1);
  assign word_flip = (st_q == ST_WR) && (hold_q ? corrupt_q : pend_nz);
  assign chk_flip  = rsp_take && mode_ro && pend_nz;
  assign consume   = (wr_hs && word_flip) || chk_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_pend_q <= '0;
      hold_q     <= 1'b0;
      corrupt_q  <= 1'b0;
    end else begin
      hold_q    <= (st_q == ST_WR) && !mem_req_ready;
      corrupt_q <= word_flip;
      if (start_go) inj_pend_q <= '0;
      else          inj_pend_q <= inj_pend_q + PIW'(inj_acc) - PIW'(consume);
    end
  end

  // Pattern units: index 0 feeds writes, index 1 regenerates expected data
  assign pat_reseed[0] = reseed_w;
  assign pat_step[0]   = wr_hs;
  assign pat_idx[0]    = addr_q;
  assign pat_reseed[1] = reseed_c;
  assign pat_step[1]   = rsp_take;
  assign pat_idx[1]    = rsp_cnt_q[AW-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_pat
    mt_pattern #(
      .DW(DW), .AW(AW), .SEED(SEED), .ARITH_OFS(ARITH_OFS)
    ) u_pat (
      .clk    (clk),
      .rst_n  (rst_n),
      .reseed (pat_reseed[g]),
      .step   (pat_step[g]),
      .src    (src_q),
      .idx    (pat_idx[g]),
      .data   (pat_data[g])
    );
  end

  assign mem_req_wdata = pat_data[0] ^ DW'(word_flip);
  assign exp_word      = pat_data[1] ^ DW'(chk_flip);
  assign mismatch      = rsp_take && (mem_rsp_data != exp_word);

  mt_sat_ctr #(.W(ECW)) u_det (
    .clk(clk), .rst_n(rst_n), .clr(counters_clear), .inc(mismatch), .q(err_detected));
  mt_sat_ctr #(.W(ECW)) u_ins (
    .clk(clk), .rst_n(rst_n), .clr(counters_clear), .inc(inj_acc), .q(err_inserted));
  mt_sat_ctr #(.W(TPW)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(wr_hs), .q(wr_words));
  mt_sat_ctr #(.W(TPW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(rsp_take), .q(rd_words));
endmodule

// File: rtl/memtest_engine_checks.sv
module mt_checks #(
  parameter int DW  = 32,
  parameter int AW  = 13,
  parameter int ECW = 32,
  parameter int TPW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_start,
  input logic           inject_req,
  input logic           counters_clear,
  input logic           running,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_we,
  input logic [AW-1:0]  mem_req_addr,
  input logic [DW-1:0]  mem_req_wdata,
  input logic [ECW-1:0] err_detected,
  input logic [ECW-1:0] err_inserted,
  input logic [TPW-1:0] wr_words,
  input logic [TPW-1:0] rd_words
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mem_req_valid);

  // R8
  idle_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && inject_req && !counters_clear) |=> $stable(err_inserted));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    counters_clear |=> (err_detected <= ECW'(1)) && (err_inserted <= ECW'(1)));

  // R7
  ins_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !counters_clear |=> (err_inserted == $past(err_inserted))
      || (err_inserted == $past(err_inserted) + 1'b1));

  // R10
  tp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (wr_words >= $past(wr_words)) && (rd_words >= $past(rd_words)));

  // R10
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && run_start) |=> (running && wr_words == '0 && rd_words == '0));
endmodule

bind memtest_engine mt_checks #(
  .DW(DW), .AW(AW), .ECW(ECW), .TPW(TPW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_start      (run_start),
  .inject_req     (inject_req),
  .counters_clear (counters_clear),
  .running        (running),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_we     (mem_req_we),
  .mem_req_addr   (mem_req_addr),
  .mem_req_wdata  (mem_req_wdata),
  .err_detected   (err_detected),
  .err_inserted   (err_inserted),
  .wr_words       (wr_words),
  .rd_words       (rd_words)
);

// File: tb/memtest_engine_tb.sv
`timescale 1ns/1ps
module memtest_engine_tb;
  localparam int TPW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cfg_addr_count = '0;
  logic [1:0]  cfg_src = '0, cfg_mode = '0;
  logic        run_start = 0, run_stop = 0, inject_req = 0, counters_clear = 0;
  logic        running, mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [12:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] err_detected, err_inserted;
  logic [TPW-1:0] wr_words, rd_words;

  always #2.5 clk = ~clk;

  memtest_engine #(.TPW(TPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr_count(cfg_addr_count), .cfg_src(cfg_src),
    .cfg_mode(cfg_mode), .run_start(run_start), .run_stop(run_stop),
    .inject_req(inject_req), .counters_clear(counters_clear), .running(running),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .err_detected(err_detected), .err_inserted(err_inserted),
    .wr_words(wr_words), .rd_words(rd_words));

  typedef struct { bit we; int addr; logic [31:0] data; } item_t;
  typedef struct { int due; logic [31:0] data; } rsp_t;

  item_t exp_q[$];
  rsp_t  rsp_q[$];
  logic [31:0] mem [int];
  int n_checks = 0, n_fail = 0, cyc = 0, hs_cnt = 0, bad_addr = -1;
  logic [15:0] rl = 16'hACE1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] prbs_next(input logic [30:0] s);
    return {s[29:0], s[30] ^ s[27]};
  endfunction

  function automatic logic [31:0] pat(input int src, input int a, input logic [30:0] s);
    logic [7:0] b;
    b = {a[3:0], ~a[3:0]};
    if (src == 0)      return {1'b0, s};
    else if (src == 1) return {4{b}};
    else               return a + 32'h1000_0000;
  endfunction

  // Driver side: push the expected request stream for a run
  task automatic plan(input int mode, input int src, input int n, input int inj_word,
                      input int iters);
    logic [30:0] s;
    item_t it;
    for (int k = 0; k < iters; k++) begin
      if (mode != 1) begin
        s = 31'h1;
        for (int a = 0; a < n; a++) begin
          it.we = 1'b1; it.addr = a; it.data = pat(src, a, s);
          if (k == 0 && a == inj_word) it.data = it.data ^ 32'h1;
          exp_q.push_back(it);
          s = prbs_next(s);
        end
      end
      if (mode != 2) begin
        for (int a = 0; a < n; a++) begin
          it.we = 1'b0; it.addr = a; it.data = '0;
          exp_q.push_back(it);
        end
      end
    end
  endtask

  // Memory model and scoreboard monitor, all at the falling edge
  initial begin
    item_t it;
    rsp_t  r;
    forever begin
      @(negedge clk);
      cyc++;
      rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
      if (rsp_q.size() > 0 && rsp_q[0].due <= cyc) begin
        r = rsp_q.pop_front();
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = r.data;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = rl[0] | rl[1];
      if (mem_req_valid && mem_req_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) begin
          check("R2", {31'b0, mem_req_we}, 32'hFFFF_FFFF, "unexpected request");
        end else begin
          it = exp_q.pop_front();
          check("R2", {31'b0, mem_req_we}, {31'b0, it.we}, "request kind");
          check("R1", {19'b0, mem_req_addr}, it.addr, "request address");
          if (it.we) check("R3/R4/R5/R7", mem_req_wdata, it.data, "write data");
        end
        if (mem_req_we) begin
          mem[int'(mem_req_addr)] = mem_req_wdata;
        end else begin
          r.due  = cyc + 2;
          r.data = mem.exists(int'(mem_req_addr)) ? mem[int'(mem_req_addr)] : '0;
          if (int'(mem_req_addr) == bad_addr) r.data = r.data ^ 32'h10;
          rsp_q.push_back(r);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Start, then one cycle later pulse stop (plus optional inject/clear)
  task automatic run_once(input int mode, input int src, input int cfg_n,
                          input bit inj, input bit clr);
    @(negedge clk);
    cfg_mode = mode[1:0]; cfg_src = src[1:0]; cfg_addr_count = cfg_n[13:0];
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    run_stop = 1'b1; inject_req = inj; counters_clear = clr;
    @(negedge clk);
    run_stop = 1'b0; inject_req = 1'b0; counters_clear = 1'b0;
    while (running) @(negedge clk);
    check("R12", exp_q.size(), 0, "items left when run ended");
    tick(3);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // reset state
    check("R10", {31'b0, running}, 0, "running after reset");
    check("R2", {31'b0, mem_req_valid}, 0, "valid after reset");
    check("R9", err_detected, 0, "detected after reset");
    check("R9", err_inserted, 0, "inserted after reset");
    check("R10", wr_words, 0, "wr_words after reset");

    // R1 low clamp with write-then-read, pseudo-random source (R3)
    plan(0, 0, 8, -1, 1);
    run_once(0, 0, 3, 0, 0);
    check("R1", wr_words, 8, "clamped write count");
    check("R2", rd_words, 8, "read count write-then-read");
    check("R6", err_detected, 0, "clean readback");

    // R4 write-only table, then read-only regenerates it
    plan(2, 1, 20, -1, 1);
    run_once(2, 1, 20, 0, 0);
    check("R2", rd_words, 0, "write-only reads");
    plan(1, 1, 20, -1, 1);
    run_once(1, 1, 20, 0, 0);
    check("R2", wr_words, 0, "read-only writes");
    check("R4", err_detected, 0, "table readback");

    // R5 arithmetic source with one bad word returned by memory (R6)
    bad_addr = 5;
    plan(0, 2, 16, -1, 1);
    run_once(0, 2, 16, 0, 0);
    bad_addr = -1;
    check("R6", err_detected, 1, "one corrupted read word");

    // R7 injection in write-then-read: word 1 carries the flip
    plan(0, 0, 8, 1, 1);
    run_once(0, 0, 8, 1, 0);
    check("R7", err_inserted, 1, "inserted after injection");
    check("R7", err_detected, 2, "detected after injection");

    // R7 injection in read-only flips the expected value
    plan(2, 1, 10, -1, 1);
    run_once(2, 1, 10, 0, 0);
    plan(1, 1, 10, -1, 1);
    run_once(1, 1, 10, 1, 0);
    check("R7", err_inserted, 2, "inserted read-only");
    check("R7", err_detected, 3, "detected read-only");

    // R8 injection while idle is ignored
    @(negedge clk); inject_req = 1'b1;
    @(negedge clk); inject_req = 1'b0;
    tick(2);
    check("R8", err_inserted, 2, "idle injection");

    // R9 clear
    @(negedge clk); counters_clear = 1'b1;
    @(negedge clk); counters_clear = 1'b0;
    check("R9", err_detected, 0, "detected cleared");
    check("R9", err_inserted, 0, "inserted cleared");

    // R9 clear and accepted injection in the same cycle
    plan(2, 2, 8, 1, 1);
    run_once(2, 2, 8, 1, 1);
    check("R9", err_inserted, 1, "clear with same-cycle injection");
    check("R9", err_detected, 0, "detected after clear");

    // R10 saturation of the write counter
    plan(2, 2, 300, -1, 1);
    run_once(2, 2, 300, 0, 0);
    check("R10", wr_words, 255, "write counter saturates");

    // R1 high clamp
    plan(2, 0, 8192, -1, 1);
    run_once(2, 0, 9000, 0, 0);
    check("R1", wr_words, 255, "high clamp run count");

    // R12 two iterations, stop mid-iteration, start ignored; R3 reseed
    plan(2, 0, 8, -1, 2);
    hs_cnt = 0;
    @(negedge clk);
    cfg_mode = 2'd2; cfg_src = 2'd0; cfg_addr_count = 14'd8; run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    while (hs_cnt < 9) @(negedge clk);
    cfg_mode = 2'd0; cfg_addr_count = 14'd40; run_start = 1'b1; run_stop = 1'b1;
    @(negedge clk);
    run_start = 1'b0; run_stop = 1'b0;
    while (running) @(negedge clk);
    check("R12", exp_q.size(), 0, "second iteration completed");
    check("R12", wr_words, 16, "two full iterations");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule